// File: doc/BRIEF.md
# Triggered Bit-Flip Fault Injector

This block sits beside a debug access path and turns a breakpoint or watchpoint hit into a memory write, with no further command needed. Software first stages an address and a data word through a load port. The data word is chosen ahead of time so that writing it flips exactly one bit of the target location. Software then arms the injector through a select/value configuration pair. The next trigger pulse sends the staged word onto the memory bus. The injector then disarms itself, and the staging register is free for ordinary debug use again.

The same staging register also serves ordinary debug reads and writes. These are launched on the rising edge of a go input. A single output stage with a register merges debug traffic and CPU traffic onto one memory port, and debug traffic always wins a conflict. A configuration bit can make the injection pulse also release the CPU from debug mode, which covers faults in internal registers or the stack that need a halted core.

The staging load port is a valid/ready stream. Ready is held high, so there is never back-pressure. A load is taken on every cycle in which valid is high. A load that arrives while the injector is armed is still consumed, but it is dropped and it flags an error.

Top module: `fault_inject_top`

## Requirements
- R1: After reset, `armed`, `stage_err`, `fi_exec`, `dbg_release`, `mem_req`, `cpu_gnt` and `dbg_rvalid` are all low.
- R2: On an edge where `cfg_sel` is high, `cfg_val[0]` becomes the armed state and `cfg_val[1]` becomes the release-on-inject setting. While `cfg_sel` is low, `cfg_val` has no effect.
- R3: A `trigger` sampled high while armed produces a `fi_exec` pulse exactly one cycle long, in the cycle after that edge.
- R4: In the cycle after the second rising edge from the trigger sample, the bus carries `mem_req=1` and `mem_we=1`, with the staged address and data.
- R5: The edge that accepts a trigger clears `armed`. A later trigger produces no pulse and no bus write.
- R6: A trigger sampled while disarmed is ignored: no `fi_exec` and no bus access.
- R7: `dbg_release` pulses together with `fi_exec` only when the release setting (`cfg_val[1]`) was stored as 1.
- R8: A staging load while armed leaves the staged address and data unchanged and sets `stage_err`, which stays high until reset.
- R9: A rising edge of `go` starts one debug access with the staged direction (`stg_we`), address and data. The access is on the bus in the cycle after the second edge. Holding `go` high starts nothing more.
- R10: When a debug access and a CPU request meet at the same edge, the debug access takes the bus and `cpu_gnt` is low for that cycle.
- R11: A debug read returns `mem_rdata` on `dbg_rdata`, with `dbg_rvalid` high for one cycle, in the cycle after the read is on the bus.
- R12: With no debug traffic, a CPU request sampled at an edge appears on the bus in the next cycle, with `cpu_gnt` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Configuration write strobe |
| cfg_val | input | 2 | Bit 0 arm, bit 1 release on inject |
| stg_valid | input | 1 | Staging load valid |
| stg_ready | output | 1 | Staging load ready (always high) |
| stg_we | input | 1 | Staged access direction, 1 = write |
| stg_addr | input | ADDR_W | Staged address |
| stg_data | input | DATA_W | Staged data word |
| go | input | 1 | Ordinary debug access launch, rising edge |
| trigger | input | 1 | Breakpoint/watchpoint hit |
| cpu_req | input | 1 | CPU bus request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_gnt | output | 1 | CPU access is on the bus this cycle |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| dbg_rdata | output | DATA_W | Debug read result |
| dbg_rvalid | output | 1 | Debug read result valid |
| fi_exec | output | 1 | Injection pulse |
| dbg_release | output | 1 | Release CPU from debug mode |
| armed | output | 1 | Injector armed |
| stage_err | output | 1 | Sticky rejected-load flag |

## Verification
The bench builds the block with ADDR_W=12 and DATA_W=16. This keeps the memory model a simple function of the address, so every debug read has a value that can be predicted. It also lets the single-bit flip sit on the top data bit, where a wrong width or slice would show. The widths change no timing, so the two-edge injection latency, the one-shot disarm, the rejected load and the collision between a CPU request and a trigger all fall inside a short directed sequence.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int CFG_W       = 2;
  localparam int CFG_ARM_BIT = 0;
  localparam int CFG_REL_BIT = 1;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DBG  = 2'd2
  } bus_own_e;
endpackage

// File: rtl/fi_stage_reg.sv
module fi_stage_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              err
);
  // The load stream never stalls; loads taken while armed are dropped.
  assign ld_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_we   <= 1'b0;
      st_addr <= '0;
      st_data <= '0;
      err     <= 1'b0;
    end else if (ld_valid) begin
      if (armed) begin
        err <= 1'b1;
      end else begin
        st_we   <= ld_we;
        st_addr <= ld_addr;
        st_data <= ld_data;
      end
    end
  end
endmodule

// File: rtl/fi_arm_ctrl.sv
module fi_arm_ctrl
  import fi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_val,
  input  logic             trigger,
  input  logic             go,
  output logic             armed,
  output logic             fi_exec,
  output logic             release_pulse,
  output logic             go_pulse
);
  logic rel_en_q;
  logic go_q;
  logic fire;

  assign fire = trigger & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed         <= 1'b0;
      rel_en_q      <= 1'b0;
      fi_exec       <= 1'b0;
      release_pulse <= 1'b0;
      go_q          <= 1'b0;
      go_pulse      <= 1'b0;
    end else begin
      fi_exec       <= fire;
      release_pulse <= fire & rel_en_q;
      go_q          <= go;
      go_pulse      <= go & ~go_q;
      // One-shot: a fire disarms even if a config write lands on the same edge.
      if (fire)
        armed <= 1'b0;
      else if (cfg_sel)
        armed <= cfg_val[CFG_ARM_BIT];
      if (cfg_sel)
        rel_en_q <= cfg_val[CFG_REL_BIT];
    end
  end
endmodule

// File: rtl/fi_bus_mux.sv
module fi_bus_mux
  import fi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_fi,
  input  logic              launch_go,
  input  logic              st_we,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cpu_gnt,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_rvalid
);
  bus_own_e own_q;
  logic     dbg_launch;
  logic     rd_pend;

  assign dbg_launch = launch_fi | launch_go;
  assign mem_req    = (own_q != OWN_IDLE);
  assign cpu_gnt    = (own_q == OWN_CPU);
  assign rd_pend    = (own_q == OWN_DBG) && !mem_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q      <= OWN_IDLE;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      dbg_rdata  <= '0;
      dbg_rvalid <= 1'b0;
    end else begin
      dbg_rvalid <= rd_pend;
      if (rd_pend)
        dbg_rdata <= mem_rdata;
      if (dbg_launch) begin
        own_q     <= OWN_DBG;
        mem_we    <= launch_fi | st_we;
        mem_addr  <= st_addr;
        mem_wdata <= st_data;
      end else if (cpu_req) begin
        own_q     <= OWN_CPU;
        mem_we    <= cpu_we;
        mem_addr  <= cpu_addr;
        mem_wdata <= cpu_wdata;
      end else begin
        own_q     <= OWN_IDLE;
        mem_we    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fault_inject_top.sv
module fault_inject_top
  import fi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_val,
  input  logic              stg_valid,
  output logic              stg_ready,
  input  logic              stg_we,
  input  logic [ADDR_W-1:0] stg_addr,
  input  logic [DATA_W-1:0] stg_data,
  input  logic              go,
  input  logic              trigger,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_rvalid,
  output logic              fi_exec,
  output logic              dbg_release,
  output logic              armed,
  output logic              stage_err
);
  logic              st_we;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic              go_pulse;

  fi_arm_ctrl u_arm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sel      (cfg_sel),
    .cfg_val      (cfg_val),
    .trigger      (trigger),
    .go           (go),
    .armed        (armed),
    .fi_exec      (fi_exec),
    .release_pulse(dbg_release),
    .go_pulse     (go_pulse)
  );

  fi_stage_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .ld_valid(stg_valid),
    .ld_ready(stg_ready),
    .ld_we   (stg_we),
    .ld_addr (stg_addr),
    .ld_data (stg_data),
    .st_we   (st_we),
    .st_addr (st_addr),
    .st_data (st_data),
    .err     (stage_err)
  );

  fi_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_fi (fi_exec),
    .launch_go (go_pulse),
    .st_we     (st_we),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cpu_gnt   (cpu_gnt),
    .dbg_rdata (dbg_rdata),
    .dbg_rvalid(dbg_rvalid)
  );
endmodule

// File: rtl/fi_checker.sv
module fi_checker (
  input logic clk,
  input logic rst_n,
  input logic fi_exec,
  input logic armed,
  input logic dbg_release,
  input logic mem_req,
  input logic mem_we,
  input logic cpu_gnt,
  input logic stage_err
);
  p_exec_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fi_exec |-> $past(armed));

  p_exec_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fi_exec |=> !fi_exec);

  p_self_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fi_exec |-> !armed);

  p_inject_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fi_exec |=> (mem_req && mem_we));

  p_release_with_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_release |-> fi_exec);

  p_dbg_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt |-> !$past(fi_exec));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stage_err) |-> stage_err);
endmodule

bind fault_inject_top fi_checker u_fi_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .fi_exec    (fi_exec),
  .armed      (armed),
  .dbg_release(dbg_release),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .cpu_gnt    (cpu_gnt),
  .stage_err  (stage_err)
);

// File: tb/fault_inject_top_tb_top.sv
`timescale 1ns/1ps
module fault_inject_top_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [1:0]    cfg_val = '0;
  logic          stg_valid = 1'b0;
  logic          stg_ready;
  logic          stg_we = 1'b0;
  logic [AW-1:0] stg_addr = '0;
  logic [DW-1:0] stg_data = '0;
  logic          go = 1'b0;
  logic          trigger = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_gnt;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dbg_rdata;
  logic          dbg_rvalid;
  logic          fi_exec;
  logic          dbg_release;
  logic          armed;
  logic          stage_err;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } bus_item_t;
  bus_item_t exp_q[$];

  always #5 clk = ~clk;

  assign mem_rdata = {4'hC, mem_addr};

  fault_inject_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .stg_valid(stg_valid), .stg_ready(stg_ready), .stg_we(stg_we),
    .stg_addr(stg_addr), .stg_data(stg_data), .go(go), .trigger(trigger),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid),
    .fi_exec(fi_exec), .dbg_release(dbg_release), .armed(armed),
    .stage_err(stage_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    bus_item_t it;
    it.we = we; it.addr = a; it.data = d;
    exp_q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Monitor: every bus cycle must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R9/R12 bus: unexpected access we=%0b addr=0x%0h expected none",
                 mem_we, mem_addr);
      end else begin
        bus_item_t e;
        e = exp_q.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr ||
            (e.we && mem_wdata !== e.data)) begin
          errors++;
          $display("FAIL R4/R9/R12 bus: actual we=%0b a=0x%0h d=0x%0h expected we=%0b a=0x%0h d=0x%0h",
                   mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 armed", armed, 0);
    check("R1 stage_err", stage_err, 0);
    check("R1 fi_exec", fi_exec, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 cpu_gnt", cpu_gnt, 0);
    check("R1 dbg_rvalid", dbg_rvalid, 0);
    check("R1 dbg_release", dbg_release, 0);

    // R12 CPU pass-through
    cpu_req = 1; cpu_we = 1; cpu_addr = 12'h0A5; cpu_wdata = 16'h1234;
    push(1, 12'h0A5, 16'h1234);
    step();
    check("R12 cpu_gnt", cpu_gnt, 1);
    cpu_req = 0;
    step();
    check("R12 idle", mem_req, 0);

    // R2 cfg_val ignored without select
    cfg_val = 2'b01; cfg_sel = 0;
    step();
    check("R2 no select", armed, 0);

    // Stage a read and launch with go (R9, R11)
    stg_valid = 1; stg_we = 0; stg_addr = 12'h123; stg_data = 16'h0;
    check("R8 stg_ready", stg_ready, 1);
    step();
    stg_valid = 0;
    go = 1;
    push(0, 12'h123, 16'h0);
    step();                                  // after edge k
    check("R9 not yet", mem_req, 0);
    step();                                  // read on bus (monitor)
    check("R9 read on bus", mem_req, 1);
    step();
    check("R11 rvalid", dbg_rvalid, 1);
    check("R11 rdata", dbg_rdata, 16'hC123);
    step();
    check("R9 held go no repeat", mem_req, 0);
    check("R11 rvalid one cycle", dbg_rvalid, 0);
    go = 0;

    // Stage the fault word (top bit flipped)
    stg_valid = 1; stg_we = 1; stg_addr = 12'h3F0; stg_data = 16'h8055;
    step();
    stg_valid = 0;

    // R6 trigger while disarmed
    trigger = 1;
    step();
    trigger = 0;
    check("R6 no exec", fi_exec, 0);
    step();
    check("R6 no write", mem_req, 0);
    step();
    check("R6 no write later", mem_req, 0);

    // R2 arm via select
    cfg_sel = 1; cfg_val = 2'b01;
    step();
    cfg_sel = 0; cfg_val = 2'b00;
    check("R2 armed", armed, 1);

    // R8 rejected load while armed
    stg_valid = 1; stg_we = 0; stg_addr = 12'h777; stg_data = 16'hFFFF;
    step();
    stg_valid = 0;
    check("R8 stage_err", stage_err, 1);
    check("R8 still armed", armed, 1);

    // R3/R4/R5/R7 injection uses the original staged word
    trigger = 1;
    push(1, 12'h3F0, 16'h8055);
    step();
    trigger = 0;
    check("R3 exec", fi_exec, 1);
    check("R5 disarmed", armed, 0);
    check("R7 no release", dbg_release, 0);
    step();
    check("R3 pulse ends", fi_exec, 0);
    check("R4 write req", mem_req, 1);
    check("R4 write we", mem_we, 1);
    check("R4 addr kept R8", mem_addr, 12'h3F0);
    check("R4 data kept R8", mem_wdata, 16'h8055);
    step();
    // R5 second trigger ignored
    trigger = 1;
    step();
    trigger = 0;
    check("R5 no second exec", fi_exec, 0);
    step();
    check("R5 no second write", mem_req, 0);

    // R7 release on inject
    cfg_sel = 1; cfg_val = 2'b11;
    step();
    cfg_sel = 0; cfg_val = 2'b00;
    trigger = 1;
    push(1, 12'h3F0, 16'h8055);
    step();
    trigger = 0;
    check("R7 release", dbg_release, 1);
    check("R7 exec", fi_exec, 1);
    step();
    check("R7 release ends", dbg_release, 0);
    step();

    // R10 debug wins over CPU
    cfg_sel = 1; cfg_val = 2'b01;
    step();
    cfg_sel = 0; cfg_val = 2'b00;
    cpu_req = 1; cpu_we = 1; cpu_addr = 12'h010; cpu_wdata = 16'hAAAA;
    trigger = 1;
    push(1, 12'h010, 16'hAAAA);
    push(1, 12'h3F0, 16'h8055);
    push(1, 12'h010, 16'hAAAA);
    step();
    trigger = 0;
    check("R10 cpu first", cpu_gnt, 1);
    step();
    check("R10 cpu blocked", cpu_gnt, 0);
    check("R10 dbg addr", mem_addr, 12'h3F0);
    step();
    check("R10 cpu resumes", cpu_gnt, 1);
    cpu_req = 0;
    step();
    check("R10 idle", mem_req, 0);
    check("R8 sticky", stage_err, 1);
    check("R10 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule